// File: doc/BRIEF.md
# Dual-Gain Optimal Filter Energy Extractor

This block reconstructs pulse amplitude and a timing product for one calorimeter readout channel. Digitized samples arrive one per bunch crossing, marked by a sample enable. Each sample carries a one-bit gain tag. The block removes a per-gain baseline from each sample and keeps a sliding window of the five most recent samples. It then forms two weighted sums over that window in parallel. The first sum is the amplitude, reported as energy. The second sum is the amplitude multiplied by the pulse time. The caller divides the second by the first to obtain the time.

Weights and baselines are held in two banks, one bank for each gain. The gain of the newest sample in a window selects the bank. The banks are written through a plain address, data and write-enable port. Each window takes a snapshot of the bank when its last sample arrives, so later writes do not change a window that is already in the pipeline. If the samples of a window do not all carry the same gain, the result is still produced but is flagged invalid.

Top module: `ofx_energy_top`

## Requirements
- R1: After reset, `res_valid` and `res_ok` are 0, and `res_energy` and `res_etime` are 0.
- R2: Every sample becomes a signed difference: its 14-bit code minus the 14-bit baseline of the window's gain. This difference is negative when the code is below the baseline.
- R3: `res_energy` equals the sum over k=0..4 of A[k] times d[k]. Here d[0] is the oldest sample of the window and d[4] is the newest.
- R4: `res_etime` equals the sum over k=0..4 of B[k] times d[k], taken over the same window and in the same order as the energy.
- R5: The gain tag of the window's newest sample selects the bank: gain 0 uses bank 0 and gain 1 uses bank 1. The baseline, the A weights and the B weights all come from that bank.
- R6: `res_valid` is a pulse one clock long. It follows the clock edge of the third sample enable after the enable that carried the window's newest sample. The outputs hold their values on every other clock, including clocks without a sample enable.
- R7: No result appears until five samples have entered since reset. The first `res_valid` follows the eighth sample enable.
- R8: `res_ok` is 1 when all five samples of the window share a gain and 0 otherwise. `res_valid` pulses in both cases.
- R9: The configuration address is 5 bits. Bit 4 selects the bank. Low index 0..4 writes A[0..4]. Low index 5..9 writes B[0..4]. Low index 10 writes the baseline from data bits 13:0. A write to low index 11..15 changes nothing.
- R10: A window uses the configuration in place at the sample enable that carries its newest sample. Writes made while the window is still in the pipeline do not affect its result.
- R11: Weights are 16-bit two's complement. Results are 36-bit two's complement at full precision, so extreme codes and weights do not wrap.
- R12: Once five samples have been received, every sample enable completes a new window. Windows overlap by four samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable, one pulse per bunch crossing |
| smp_code | input | 14 | Unsigned ADC code |
| smp_gain | input | 1 | Gain tag of the sample |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Bank (bit 4) and field index (bits 3:0) |
| cfg_wdata | input | 16 | Weight or baseline value |
| res_valid | output | 1 | Result pulse |
| res_ok | output | 1 | Window gain was uniform |
| res_energy | output | 36 | Signed amplitude sum |
| res_etime | output | 36 | Signed amplitude-times-time sum |

## Verification
The bench sweeps codes across the full 14-bit range, and some codes fall below the baseline so that negative differences are checked against positive ones. A single-spike pattern on a flat baseline exposes any reversal or misalignment of weight order, because each tap produces a distinct output. A run on gain 1 confirms the bank selection, and a run with gains alternating every three samples separates uniform windows from mixed ones. Further runs cover writes to unused indices, writes issued while windows are in flight, enables both back to back and with gaps, and maximum-magnitude operands to show that full precision is kept.

// File: rtl/ofx_pkg.sv
`timescale 1ns/1ps
package ofx_pkg;
    localparam int NTAP    = 5;
    localparam int NGAIN   = 2;
    localparam int SMP_W   = 14;
    localparam int COEF_W  = 16;
    localparam int ACC_W   = 36;
    localparam int DIFF_W  = SMP_W + 1;
    localparam int IDX_W   = 4;
    localparam int TAP_W   = $clog2(NTAP);
    localparam int PED_IDX = 2 * NTAP;
    localparam int NPATH   = 2;

    typedef logic [SMP_W-1:0]                code_t;
    typedef logic signed [DIFF_W-1:0]        diff_t;
    typedef logic signed [ACC_W-1:0]         acc_t;
    typedef logic [NTAP-1:0][COEF_W-1:0]     coef_vec_t;
    typedef logic [NTAP-1:0][DIFF_W-1:0]     diff_vec_t;

    typedef struct packed {
        logic             bank;
        logic [IDX_W-1:0] idx;
    } cfg_addr_t;

    typedef enum logic [1:0] {FLD_A, FLD_B, FLD_PED, FLD_NONE} fld_e;

    function automatic fld_e fld_decode(logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(NTAP))            return FLD_A;
        else if (idx < IDX_W'(2 * NTAP))   return FLD_B;
        else if (idx == IDX_W'(PED_IDX))   return FLD_PED;
        else                               return FLD_NONE;
    endfunction

    function automatic logic [TAP_W-1:0] fld_tap(logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] t;
        t = (idx < IDX_W'(NTAP)) ? idx : idx - IDX_W'(NTAP);
        return t[TAP_W-1:0];
    endfunction

    function automatic diff_t ped_sub(code_t c, code_t p);
        return diff_t'({1'b0, c}) - diff_t'({1'b0, p});
    endfunction

    function automatic acc_t wmul(logic [DIFF_W-1:0] d, logic [COEF_W-1:0] c);
        acc_t dx;
        acc_t cx;
        dx = acc_t'($signed(d));
        cx = acc_t'($signed(c));
        return dx * cx;
    endfunction
endpackage

// File: rtl/ofx_cfg_bank.sv
`timescale 1ns/1ps
module ofx_cfg_bank
    import ofx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cfg_addr_t addr,
    input  logic [COEF_W-1:0] wdata,
    input  logic      sel_gain,
    output code_t     sel_ped,
    output coef_vec_t sel_a,
    output coef_vec_t sel_b
);
    coef_vec_t coef_a_q [NGAIN];
    coef_vec_t coef_b_q [NGAIN];
    code_t     ped_q    [NGAIN];

    fld_e             fld;
    logic [TAP_W-1:0] tap;

    assign fld = fld_decode(addr.idx);
    assign tap = fld_tap(addr.idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NGAIN; g++) begin
                coef_a_q[g] <= '0;
                coef_b_q[g] <= '0;
                ped_q[g]    <= '0;
            end
        end else if (we) begin
            case (fld)
                FLD_A:   coef_a_q[addr.bank][tap] <= wdata;
                FLD_B:   coef_b_q[addr.bank][tap] <= wdata;
                FLD_PED: ped_q[addr.bank]         <= wdata[SMP_W-1:0];
                default: ;
            endcase
        end
    end

    assign sel_ped = ped_q[sel_gain];
    assign sel_a   = coef_a_q[sel_gain];
    assign sel_b   = coef_b_q[sel_gain];

    for (genvar g = 0; g < NGAIN; g++) begin : g_chk
        p_ped_write_r9: assert property (@(posedge clk) disable iff (rst)
            (we && addr.bank == g && fld == FLD_PED)
            |=> ped_q[g] == $past(wdata[SMP_W-1:0]));
        p_bad_idx_r9: assert property (@(posedge clk) disable iff (rst)
            (we && fld == FLD_NONE)
            |=> ($stable(ped_q[g]) && $stable(coef_a_q[g]) && $stable(coef_b_q[g])));
    end
endmodule

// File: rtl/ofx_window.sv
`timescale 1ns/1ps
module ofx_window
    import ofx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  code_t     code,
    input  logic      gain,
    input  code_t     ped,
    input  coef_vec_t ca_in,
    input  coef_vec_t cb_in,
    output logic      a_valid,
    output logic      a_ok,
    output diff_vec_t a_diff,
    output coef_vec_t a_ca,
    output coef_vec_t a_cb
);
    localparam int HIST   = NTAP - 1;
    localparam int FILL_W = $clog2(NTAP + 1);

    code_t             hist_q [HIST];
    logic [HIST-1:0]   ghist_q;
    logic [FILL_W-1:0] fill_q;

    code_t             win_n [NTAP];
    logic [NTAP-1:0]   gwin_n;
    diff_vec_t         diff_n;
    logic              full_n;
    logic              ok_n;

    always_comb begin
        for (int i = 0; i < HIST; i++) begin
            win_n[i]  = hist_q[i];
            gwin_n[i] = ghist_q[i];
        end
        win_n[HIST]  = code;
        gwin_n[HIST] = gain;
        for (int i = 0; i < NTAP; i++) begin
            diff_n[i] = ped_sub(win_n[i], ped);
        end
        full_n = (fill_q >= FILL_W'(HIST));
        ok_n   = (gwin_n == '0) || (gwin_n == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
            ghist_q <= '0;
            fill_q  <= '0;
            a_valid <= 1'b0;
            a_ok    <= 1'b0;
            a_diff  <= '0;
            a_ca    <= '0;
            a_cb    <= '0;
        end else if (en) begin
            for (int i = 0; i < HIST; i++) begin
                hist_q[i]  <= win_n[i+1];
                ghist_q[i] <= gwin_n[i+1];
            end
            if (fill_q != FILL_W'(NTAP)) fill_q <= fill_q + FILL_W'(1);
            a_valid <= full_n;
            a_ok    <= ok_n;
            a_diff  <= diff_n;
            a_ca    <= ca_in;
            a_cb    <= cb_in;
        end
    end

    p_fill_r7: assert property (@(posedge clk) disable iff (rst)
        a_valid |-> fill_q == FILL_W'(NTAP));

    p_ok_uniform_r8: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_ok) |-> ($countones(ghist_q) == 0 || $countones(ghist_q) == HIST));
endmodule

// File: rtl/ofx_wsum.sv
`timescale 1ns/1ps
module ofx_wsum
    import ofx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      in_valid,
    input  logic      in_ok,
    input  diff_vec_t diff,
    input  coef_vec_t coef,
    output logic      out_valid,
    output logic      out_ok,
    output acc_t      out_sum
);
    acc_t prod_q [NTAP];
    logic vb_q, okb_q;
    acc_t sum_n, sum_q;
    logic vc_q, okc_q;

    always_comb begin
        sum_n = '0;
        for (int i = 0; i < NTAP; i++) sum_n = sum_n + prod_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAP; i++) prod_q[i] <= '0;
            vb_q      <= 1'b0;
            okb_q     <= 1'b0;
            sum_q     <= '0;
            vc_q      <= 1'b0;
            okc_q     <= 1'b0;
            out_valid <= 1'b0;
            out_ok    <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= en && vc_q;
            if (en) begin
                for (int i = 0; i < NTAP; i++) prod_q[i] <= wmul(diff[i], coef[i]);
                vb_q  <= in_valid;
                okb_q <= in_ok;
                sum_q <= sum_n;
                vc_q  <= vb_q;
                okc_q <= okb_q;
                if (vc_q) begin
                    out_sum <= sum_q;
                    out_ok  <= okc_q;
                end
            end
        end
    end

    p_valid_after_en_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(en));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_sum) && $stable(out_ok)));
endmodule

// File: rtl/ofx_energy_top.sv
`timescale 1ns/1ps
module ofx_energy_top
    import ofx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic [SMP_W-1:0]  smp_code,
    input  logic              smp_gain,
    input  logic              cfg_we,
    input  logic [IDX_W:0]    cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    output logic              res_valid,
    output logic              res_ok,
    output logic [ACC_W-1:0]  res_energy,
    output logic [ACC_W-1:0]  res_etime
);
    code_t     sel_ped;
    coef_vec_t sel_a, sel_b;
    logic      a_valid, a_ok;
    diff_vec_t a_diff;
    coef_vec_t a_ca, a_cb;

    coef_vec_t csel [NPATH];
    logic      vld  [NPATH];
    logic      okv  [NPATH];
    acc_t      sums [NPATH];

    ofx_cfg_bank u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr_t'(cfg_addr)),
        .wdata    (cfg_wdata),
        .sel_gain (smp_gain),
        .sel_ped  (sel_ped),
        .sel_a    (sel_a),
        .sel_b    (sel_b)
    );

    ofx_window u_win (
        .clk     (clk),
        .rst     (rst),
        .en      (smp_en),
        .code    (smp_code),
        .gain    (smp_gain),
        .ped     (sel_ped),
        .ca_in   (sel_a),
        .cb_in   (sel_b),
        .a_valid (a_valid),
        .a_ok    (a_ok),
        .a_diff  (a_diff),
        .a_ca    (a_ca),
        .a_cb    (a_cb)
    );

    assign csel[0] = a_ca;
    assign csel[1] = a_cb;

    for (genvar k = 0; k < NPATH; k++) begin : g_path
        ofx_wsum u_sum (
            .clk       (clk),
            .rst       (rst),
            .en        (smp_en),
            .in_valid  (a_valid),
            .in_ok     (a_ok),
            .diff      (a_diff),
            .coef      (csel[k]),
            .out_valid (vld[k]),
            .out_ok    (okv[k]),
            .out_sum   (sums[k])
        );
    end

    assign res_valid  = vld[0] & vld[1];
    assign res_ok     = okv[0] & okv[1];
    assign res_energy = sums[0];
    assign res_etime  = sums[1];

    p_paths_agree_r4: assert property (@(posedge clk) disable iff (rst)
        (vld[0] == vld[1]) && (okv[0] == okv[1]));
endmodule

// File: tb/ofx_energy_top_tb_top.sv
`timescale 1ns/1ps
module ofx_energy_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_en;
    logic [13:0] smp_code;
    logic        smp_gain;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        res_valid, res_ok;
    logic [35:0] res_energy, res_etime;

    always #4 clk = ~clk;

    ofx_energy_top dut_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .smp_code(smp_code),
        .smp_gain(smp_gain), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_ok(res_ok),
        .res_energy(res_energy), .res_etime(res_etime)
    );

    int     nchk = 0;
    int     nfail = 0;
    int     npush = 0;
    longint m_a [2][5];
    longint m_b [2][5];
    longint m_ped [2];
    int     hc [0:511];
    bit     hg [0:511];
    longint ee [0:511];
    longint et [0:511];
    bit     eok [0:511];
    string  tge [0:511];
    string  tgt [0:511];

    function automatic longint sx(logic [35:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        nchk++;
        if (!good) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit g, input int idx, input int val);
        @(negedge clk);
        smp_en    = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = {g, idx[3:0]};
        cfg_wdata = val[15:0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 5) m_a[g][idx] = longint'($signed(val[15:0]));
        else if (idx < 10) m_b[g][idx-5] = longint'($signed(val[15:0]));
        else if (idx == 10) m_ped[g] = longint'(val[13:0]);
    endtask

    task automatic push(input int code, input bit g, input string te, input string tt);
        longint e, t, d;
        bit same;
        int k;
        npush++;
        hc[npush] = code;
        hg[npush] = g;
        if (npush >= 5) begin
            e = 0; t = 0; same = 1'b1;
            for (int i = 0; i < 5; i++) begin
                d = longint'(hc[npush-4+i]) - m_ped[g];
                e += d * m_a[g][i];
                t += d * m_b[g][i];
                if (hg[npush-4+i] != g) same = 1'b0;
            end
            ee[npush] = e; et[npush] = t; eok[npush] = same;
            tge[npush] = te; tgt[npush] = tt;
        end
        @(negedge clk);
        smp_en   = 1'b1;
        smp_code = code[13:0];
        smp_gain = g;
        @(posedge clk);
        #1;
        if (npush >= 8) begin
            k = npush - 3;
            chk(res_valid === 1'b1, "R6 R12 valid", longint'(res_valid), 1);
            if (eok[k]) begin
                chk(res_ok === 1'b1, "R8 ok", longint'(res_ok), 1);
                chk(sx(res_energy) == ee[k], tge[k], sx(res_energy), ee[k]);
                chk(sx(res_etime) == et[k], tgt[k], sx(res_etime), et[k]);
            end else begin
                chk(res_ok === 1'b0, "R8 mixed", longint'(res_ok), 0);
            end
        end else begin
            chk(res_valid === 1'b0, "R7 fill", longint'(res_valid), 0);
        end
    endtask

    task automatic idle(input int n);
        longint le, lt;
        @(negedge clk);
        smp_en = 1'b0;
        le = sx(res_energy);
        lt = sx(res_etime);
        repeat (n) begin
            @(posedge clk);
            #1;
            chk(res_valid === 1'b0, "R6 idle pulse", longint'(res_valid), 0);
            chk(sx(res_energy) == le && sx(res_etime) == lt, "R6 hold", sx(res_energy), le);
        end
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int ca0 [5] = '{3, -5, 7, 11, -13};
        int cb0 [5] = '{-2, 9, 4, -6, 1};
        int ca1 [5] = '{100, -200, 300, 50, -25};
        int cb1 [5] = '{17, -33, 8, 1, -4};
        for (int g = 0; g < 2; g++) begin
            m_ped[g] = 0;
            for (int i = 0; i < 5; i++) begin m_a[g][i] = 0; m_b[g][i] = 0; end
        end
        rst = 1'b1; smp_en = 1'b0; smp_code = '0; smp_gain = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1 reset state
        chk(res_valid === 1'b0, "R1 valid", longint'(res_valid), 0);
        chk(res_ok === 1'b0, "R1 ok", longint'(res_ok), 0);
        chk(sx(res_energy) == 0, "R1 energy", sx(res_energy), 0);
        chk(sx(res_etime) == 0, "R1 etime", sx(res_etime), 0);

        for (int i = 0; i < 5; i++) begin
            wr(1'b0, i, ca0[i]); wr(1'b0, 5 + i, cb0[i]);
            wr(1'b1, i, ca1[i]); wr(1'b1, 5 + i, cb1[i]);
        end
        wr(1'b0, 10, 1000);
        wr(1'b1, 10, 50);

        // R2 R3 R4: sweep across code range, some below baseline
        for (int c = 0; c < 50; c++) push((c * 331) % 16384, 1'b0, "R2 R3 energy", "R4 etime");
        idle(3);
        // R3 single spike on flat baseline: tap order
        for (int c = 0; c < 6; c++) push(1000, 1'b0, "R3 spike", "R4 spike");
        push(5000, 1'b0, "R3 spike", "R4 spike");
        for (int c = 0; c < 6; c++) push(1000, 1'b0, "R3 spike", "R4 spike");
        // R5 second bank
        for (int c = 0; c < 20; c++) push((c * 977 + 50) % 16384, 1'b1, "R5 energy", "R5 etime");
        // R8 gain toggles every three samples
        for (int c = 0; c < 20; c++) push(2000 + c * 113, bit'((c / 3) % 2), "R8 energy", "R8 etime");
        // R9 writes to unused indices must change nothing
        wr(1'b0, 11, 777); wr(1'b0, 15, -5); wr(1'b1, 13, 1234); wr(1'b1, 12, -32768);
        for (int c = 0; c < 8; c++) push(3000 + c * 700, 1'b0, "R9 energy", "R9 etime");
        // R10 writes while windows are in flight
        for (int c = 0; c < 12; c++) begin
            push(4000 + c * 321, 1'b0, "R10 energy", "R10 etime");
            if (c == 3) wr(1'b0, 2, 999);
            if (c == 7) begin wr(1'b0, 10, 3500); wr(1'b0, 9, -77); end
        end
        // R6 enables with gaps
        for (int c = 0; c < 10; c++) begin
            push(6000 + c * 50, 1'b0, "R6 energy", "R6 etime");
            idle(c % 3 + 1);
        end
        // R11 extreme operands
        for (int i = 0; i < 5; i++) begin wr(1'b0, i, -32768); wr(1'b0, 5 + i, 32767); end
        wr(1'b0, 10, 0);
        for (int c = 0; c < 8; c++) push(16383, 1'b0, "R11 energy", "R11 etime");
        wr(1'b0, 10, 16383);
        for (int c = 0; c < 8; c++) push(0, 1'b0, "R11 neg energy", "R11 neg etime");

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule